// File: doc/BRIEF.md
# Two-Level Address Translation Unit with Translation Cache

This block turns 32-bit virtual addresses into physical addresses. A request carries the virtual address, a write flag and a user-mode flag. The user-mode flag is taken from bit 5 of the processor flag word. The block first searches a small fully associative translation cache. On a miss it walks a two-level table in memory through its own memory port. The first level is a directory of 1024 words. Each directory word points to a page table of 1024 words.

The virtual address splits into three fields. Bits 31..22 index the directory, bits 21..12 index the page table, and bits 11..0 are the byte offset. A table word encodes the following:
- bit 0: present
- bit 1: writable
- bit 2: user-accessible
- bit 5: accessed
- bits 31..12: frame number
- bits 11..8: must be zero

Bits 3, 4, 6 and 7 carry no meaning to this block. A failed translation returns a fault flag together with exception vector 5. Faults never install an entry in the cache. A separate invalidate port drops the cache entry for one virtual page.

Top module: `vmx_xlate`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid` and `mem_req` are 0, and the translation cache holds no entries. A page used before the reset must be walked again after it.
- R2: When a request is accepted (`req_valid` and `req_ready` at a clock edge) and its page is cached, `rsp_valid` is 1 in the next cycle. `rsp_paddr` is {cached frame, vaddr[11:0]} and no memory access takes place.
- R3: On a miss the block first reads the word at `dir_base` + 4*vaddr[31:22]. It then reads the word at {directory word[31:12], 12'h000} + 4*vaddr[21:12]. The response is {page word[31:12], vaddr[11:0]}. `mem_req` stays high with a stable address until `mem_ack`.
- R4: If the page word has bit 5 clear, the block writes that word back to the same address with bit 5 (value 0x20) set before it responds. If bit 5 is already set, no write happens.
- R5: The response is a fault if either level has bit 0 clear or has any of bits 11..8 set. A fault has `rsp_fault`=1, `rsp_vector`=5 and `rsp_paddr`=0. A faulting access leaves nothing in the cache, so the next access to that page walks again.
- R6: A write to a page whose bit 1 is clear faults. A user access to a page whose bit 2 is clear faults. Both checks also apply to cache hits, and a hit makes no memory access.
- R7: A pulse on `inv_valid` removes only the cached entry whose page equals `inv_vaddr`[31:12]. Other cached pages keep hitting.
- R8: The cache holds 8 entries and replaces them in round-robin order. After reset, the ninth distinct page evicts the first page filled, and the tenth evicts the second.
- R9: Only one translation is in flight. `req_ready` is 0 for the whole walk.
- R10: If an invalidate for a page is present in the same cycle as the fill for that page, the fill is dropped. The response is still correct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is made in user mode |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 1 | Translation failed |
| rsp_vector | output | 8 | Exception vector on fault (5), else 0 |
| rsp_paddr | output | 32 | Physical address, 0 on fault |
| dir_base | input | 32 | Byte address of the directory |
| mem_req | output | 1 | Table access request, held until acknowledged |
| mem_we | output | 1 | Table access is a write |
| mem_addr | output | 32 | Table word byte address |
| mem_wdata | output | 32 | Write-back data |
| mem_ack | input | 1 | Access done; read data valid this cycle |
| mem_rdata | input | 32 | Read data |
| inv_valid | input | 1 | Invalidate strobe |
| inv_vaddr | input | 32 | Virtual address whose page is invalidated |

## Verification
The hardest case to reach from the ports is an invalidate that lands in the exact cycle a walk installs its result. That cycle depends on the latency of the memory model. The bench therefore holds `inv_valid` on the target page for the entire walk, so the invalidate is present at the fill edge whatever the latency is. It then shows through the memory read count that the next access walks again. Round-robin eviction is reached by resetting the block and filling nine pages in a known order.

// File: rtl/vmx_pkg.sv
// Shared constants and types for the translation unit.
// Assumes 32-bit addresses, 4 KiB pages and 32-bit table words.
package vmx_pkg;
    localparam int ADDR_W   = 32;
    localparam int OFF_W    = 12;
    localparam int IDX_W    = 10;
    localparam int PN_W     = ADDR_W - OFF_W;
    localparam int PRES_BIT = 0;
    localparam int RW_BIT   = 1;
    localparam int USR_BIT  = 2;
    localparam int ACC_BIT  = 5;
    localparam logic [ADDR_W-1:0] ACC_MASK = 32'd1 << ACC_BIT;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DIR,
        ST_PTE,
        ST_WB
    } walk_st_t;

    typedef struct packed {
        logic            valid;
        logic [PN_W-1:0] vpn;
        logic [PN_W-1:0] ppn;
        logic            wr;
        logic            usr;
    } tlb_ent_t;
endpackage

// File: rtl/vmx_tlb.sv
// Fully associative translation cache with round-robin replacement.
// Assumes a fill is never issued for a page that is already cached.
module vmx_tlb
    import vmx_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PN_W-1:0]    lk_vpn,
    output logic               lk_hit,
    output logic [PN_W-1:0]    lk_ppn,
    output logic               lk_wr,
    output logic               lk_usr,
    output logic [ENTRIES-1:0] hit_vec,
    input  logic               fill_en,
    input  logic [PN_W-1:0]    fill_vpn,
    input  logic [PN_W-1:0]    fill_ppn,
    input  logic               fill_wr,
    input  logic               fill_usr,
    input  logic               inv_en,
    input  logic [PN_W-1:0]    inv_vpn
);
    localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(ENTRIES - 1);

    tlb_ent_t         ents [ENTRIES];
    logic [PTR_W-1:0] ptr;

    // Per-entry match lines.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_match
        assign hit_vec[g] = ents[g].valid && (ents[g].vpn == lk_vpn);
    end

    // Merge the single matching entry onto the lookup outputs.
    always_comb begin
        lk_ppn = '0;
        lk_wr  = 1'b0;
        lk_usr = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hit_vec[i]) begin
                lk_ppn = lk_ppn | ents[i].ppn;
                lk_wr  = lk_wr  | ents[i].wr;
                lk_usr = lk_usr | ents[i].usr;
            end
        end
    end
    assign lk_hit = |hit_vec;

    // Apply invalidates, then install a fill at the round-robin slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) ents[i] <= '0;
            ptr <= '0;
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (inv_en && ents[i].valid && ents[i].vpn == inv_vpn)
                    ents[i].valid <= 1'b0;
            end
            if (fill_en && !(inv_en && inv_vpn == fill_vpn)) begin
                ents[ptr] <= '{valid: 1'b1, vpn: fill_vpn, ppn: fill_ppn,
                               wr: fill_wr, usr: fill_usr};
                ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
            end
        end
    end
endmodule

// File: rtl/vmx_walker.sv
// Request sequencer and two-level table walker.
// Answers cache hits in one cycle; on a miss it reads the directory word,
// then the page word, and writes the accessed bit back if it was clear.
// Assumes mem_rdata is valid in the cycle mem_ack is high.
module vmx_walker
    import vmx_pkg::*;
#(
    parameter int VEC_W     = 8,
    parameter int FAULT_VEC = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic              req_write,
    input  logic              req_user,
    input  logic              lk_hit,
    input  logic [PN_W-1:0]   lk_ppn,
    input  logic              lk_wr,
    input  logic              lk_usr,
    output logic              fill_en,
    output logic [PN_W-1:0]   fill_vpn,
    output logic [PN_W-1:0]   fill_ppn,
    output logic              fill_wr,
    output logic              fill_usr,
    input  logic [ADDR_W-1:0] dir_base,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [ADDR_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [ADDR_W-1:0] mem_rdata,
    output logic              rsp_valid,
    output logic              rsp_fault,
    output logic [VEC_W-1:0]  rsp_vector,
    output logic [ADDR_W-1:0] rsp_paddr
);
    localparam int PAD_DIR = ADDR_W - IDX_W - 2;

    walk_st_t          state;
    logic [ADDR_W-1:0] va_q;
    logic              wr_q, usr_q;
    logic [PN_W-1:0]   tbl_q;
    logic [ADDR_W-1:0] pte_q;
    logic              word_ok, perm_bad, hit_bad;

    // Frame and presence check of the word being read.
    assign word_ok  = mem_rdata[PRES_BIT] && (mem_rdata[11:8] == 4'h0);
    // Permission check of a page word against the latched access.
    assign perm_bad = (wr_q && !mem_rdata[RW_BIT]) || (usr_q && !mem_rdata[USR_BIT]);
    // Permission check of a cached translation against the live request.
    assign hit_bad  = (req_write && !lk_wr) || (req_user && !lk_usr);

    // Memory port driven from the walk state.
    always_comb begin
        mem_req   = (state != ST_IDLE);
        mem_we    = (state == ST_WB);
        mem_wdata = pte_q | ACC_MASK;
        if (state == ST_DIR)
            mem_addr = dir_base + {{PAD_DIR{1'b0}}, va_q[ADDR_W-1 -: IDX_W], 2'b00};
        else
            mem_addr = {tbl_q, {OFF_W{1'b0}}}
                     + {{PAD_DIR{1'b0}}, va_q[OFF_W +: IDX_W], 2'b00};
    end

    // Cache fill at the edge that finishes a successful walk.
    always_comb begin
        fill_vpn = va_q[ADDR_W-1:OFF_W];
        if (state == ST_WB) begin
            fill_en  = mem_ack;
            fill_ppn = pte_q[ADDR_W-1:OFF_W];
            fill_wr  = pte_q[RW_BIT];
            fill_usr = pte_q[USR_BIT];
        end else begin
            fill_en  = mem_ack && (state == ST_PTE) && word_ok && !perm_bad
                     && mem_rdata[ACC_BIT];
            fill_ppn = mem_rdata[ADDR_W-1:OFF_W];
            fill_wr  = mem_rdata[RW_BIT];
            fill_usr = mem_rdata[USR_BIT];
        end
    end

    assign req_ready = (state == ST_IDLE);

    // Walk sequencing and registered response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            va_q       <= '0;
            wr_q       <= 1'b0;
            usr_q      <= 1'b0;
            tbl_q      <= '0;
            pte_q      <= '0;
            rsp_valid  <= 1'b0;
            rsp_fault  <= 1'b0;
            rsp_vector <= '0;
            rsp_paddr  <= '0;
        end else begin
            rsp_valid <= 1'b0;
            case (state)
                ST_IDLE: if (req_valid) begin
                    if (lk_hit) begin
                        rsp_valid  <= 1'b1;
                        rsp_fault  <= hit_bad;
                        rsp_vector <= hit_bad ? VEC_W'(FAULT_VEC) : '0;
                        rsp_paddr  <= hit_bad ? '0 : {lk_ppn, req_vaddr[OFF_W-1:0]};
                    end else begin
                        va_q  <= req_vaddr;
                        wr_q  <= req_write;
                        usr_q <= req_user;
                        state <= ST_DIR;
                    end
                end
                ST_DIR: if (mem_ack) begin
                    tbl_q <= mem_rdata[ADDR_W-1:OFF_W];
                    if (word_ok) begin
                        state <= ST_PTE;
                    end else begin
                        state      <= ST_IDLE;
                        rsp_valid  <= 1'b1;
                        rsp_fault  <= 1'b1;
                        rsp_vector <= VEC_W'(FAULT_VEC);
                        rsp_paddr  <= '0;
                    end
                end
                ST_PTE: if (mem_ack) begin
                    pte_q <= mem_rdata;
                    if (!word_ok || perm_bad) begin
                        state      <= ST_IDLE;
                        rsp_valid  <= 1'b1;
                        rsp_fault  <= 1'b1;
                        rsp_vector <= VEC_W'(FAULT_VEC);
                        rsp_paddr  <= '0;
                    end else if (!mem_rdata[ACC_BIT]) begin
                        state <= ST_WB;
                    end else begin
                        state      <= ST_IDLE;
                        rsp_valid  <= 1'b1;
                        rsp_fault  <= 1'b0;
                        rsp_vector <= '0;
                        rsp_paddr  <= {mem_rdata[ADDR_W-1:OFF_W], va_q[OFF_W-1:0]};
                    end
                end
                default: if (mem_ack) begin
                    state      <= ST_IDLE;
                    rsp_valid  <= 1'b1;
                    rsp_fault  <= 1'b0;
                    rsp_vector <= '0;
                    rsp_paddr  <= {pte_q[ADDR_W-1:OFF_W], va_q[OFF_W-1:0]};
                end
            endcase
        end
    end
endmodule

// File: rtl/vmx_xlate.sv
// Top of the translation unit: translation cache plus table walker.
// Assumes one translation in flight and a directory aligned to 4 bytes.
module vmx_xlate
    import vmx_pkg::*;
#(
    parameter int TLB_ENTRIES = 8,
    parameter int VEC_W       = 8,
    parameter int FAULT_VEC   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [31:0]       req_vaddr,
    input  logic              req_write,
    input  logic              req_user,
    output logic              rsp_valid,
    output logic              rsp_fault,
    output logic [VEC_W-1:0]  rsp_vector,
    output logic [31:0]       rsp_paddr,
    input  logic [31:0]       dir_base,
    output logic              mem_req,
    output logic              mem_we,
    output logic [31:0]       mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    input  logic              inv_valid,
    input  logic [31:0]       inv_vaddr
);
    logic                   tlb_hit, tlb_wr, tlb_usr;
    logic [PN_W-1:0]        tlb_ppn;
    logic [TLB_ENTRIES-1:0] tlb_hit_vec;
    logic                   fill_en, fill_wr, fill_usr;
    logic [PN_W-1:0]        fill_vpn, fill_ppn;

    vmx_tlb #(.ENTRIES(TLB_ENTRIES)) u_tlb (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_vpn   (req_vaddr[ADDR_W-1:OFF_W]),
        .lk_hit   (tlb_hit),
        .lk_ppn   (tlb_ppn),
        .lk_wr    (tlb_wr),
        .lk_usr   (tlb_usr),
        .hit_vec  (tlb_hit_vec),
        .fill_en  (fill_en),
        .fill_vpn (fill_vpn),
        .fill_ppn (fill_ppn),
        .fill_wr  (fill_wr),
        .fill_usr (fill_usr),
        .inv_en   (inv_valid),
        .inv_vpn  (inv_vaddr[ADDR_W-1:OFF_W])
    );

    vmx_walker #(.VEC_W(VEC_W), .FAULT_VEC(FAULT_VEC)) u_walk (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_vaddr  (req_vaddr),
        .req_write  (req_write),
        .req_user   (req_user),
        .lk_hit     (tlb_hit),
        .lk_ppn     (tlb_ppn),
        .lk_wr      (tlb_wr),
        .lk_usr     (tlb_usr),
        .fill_en    (fill_en),
        .fill_vpn   (fill_vpn),
        .fill_ppn   (fill_ppn),
        .fill_wr    (fill_wr),
        .fill_usr   (fill_usr),
        .dir_base   (dir_base),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata),
        .rsp_valid  (rsp_valid),
        .rsp_fault  (rsp_fault),
        .rsp_vector (rsp_vector),
        .rsp_paddr  (rsp_paddr)
    );
endmodule

// File: rtl/vmx_xlate_chk.sv
// Protocol and response-form checks for vmx_xlate, attached by bind.
module vmx_xlate_chk #(
    parameter int TLB_ENTRIES = 8,
    parameter int VEC_W       = 8,
    parameter int FAULT_VEC   = 5
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   req_valid,
    input logic                   req_ready,
    input logic                   rsp_valid,
    input logic                   rsp_fault,
    input logic [VEC_W-1:0]       rsp_vector,
    input logic [31:0]            rsp_paddr,
    input logic                   mem_req,
    input logic                   mem_we,
    input logic [31:0]            mem_addr,
    input logic [31:0]            mem_wdata,
    input logic                   mem_ack,
    input logic                   tlb_hit,
    input logic [TLB_ENTRIES-1:0] tlb_hit_vec
);
    // R9: no new request is accepted while a walk uses memory.
    a_r9_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !req_ready);

    // R3: a table access is held with a stable address until acknowledged.
    a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R4: every write-back is a present word with the accessed bit set.
    a_r4_wb_marks: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_wdata[5] && mem_wdata[0]));

    // R5: a fault carries vector 5 and a zero address.
    a_r5_fault_form: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_paddr == 32'h0 && rsp_vector == VEC_W'(FAULT_VEC)));

    // R2: an accepted hit answers in the next cycle without a walk.
    a_r2_hit_next: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && tlb_hit) |=> (rsp_valid && !mem_req));

    // R8: at most one cache entry matches a page.
    a_r8_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tlb_hit_vec));
endmodule

bind vmx_xlate vmx_xlate_chk #(
    .TLB_ENTRIES (TLB_ENTRIES),
    .VEC_W       (VEC_W),
    .FAULT_VEC   (FAULT_VEC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .rsp_valid   (rsp_valid),
    .rsp_fault   (rsp_fault),
    .rsp_vector  (rsp_vector),
    .rsp_paddr   (rsp_paddr),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_ack     (mem_ack),
    .tlb_hit     (tlb_hit),
    .tlb_hit_vec (tlb_hit_vec)
);

// File: tb/vmx_xlate_bench.sv
// Directed bench for vmx_xlate with a behavioural table memory.
module vmx_xlate_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic        rsp_valid, rsp_fault;
    logic [7:0]  rsp_vector;
    logic [31:0] rsp_paddr;
    logic [31:0] dir_base = 32'h0010_0000;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        inv_valid = 1'b0;
    logic [31:0] inv_vaddr = '0;

    always #2 clk = ~clk;

    vmx_xlate u_vmx_xlate (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_write(req_write), .req_user(req_user),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_vector(rsp_vector),
        .rsp_paddr(rsp_paddr), .dir_base(dir_base), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .inv_valid(inv_valid),
        .inv_vaddr(inv_vaddr)
    );

    logic [31:0] mem [logic [31:0]];
    int rd_cnt = 0, wr_cnt = 0;
    int checks = 0, fails = 0, cycles = 0;
    int ready_busy = 0;

    function automatic logic [31:0] mread(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    // Memory model: acknowledges each access one cycle after it appears.
    always @(posedge clk) begin
        mem_ack <= 1'b0;
        if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) begin
                mem[mem_addr] = mem_wdata;
                wr_cnt++;
            end else begin
                mem_rdata <= mread(mem_addr);
                rd_cnt++;
            end
        end
    end

    task automatic fin();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++; fails++;
            $display("FAIL watchdog: act=%0d cycles exp=<100000", cycles);
            fin();
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] dir_addr(input logic [31:0] va);
        return dir_base + {20'h0, va[31:22], 2'b00};
    endfunction
    function automatic logic [31:0] pte_addr(input logic [19:0] tf, input logic [31:0] va);
        return {tf, 12'h0} + {20'h0, va[21:12], 2'b00};
    endfunction

    // Install both levels for one virtual page.
    task automatic map(input logic [31:0] va, input logic [19:0] tf, input logic [11:0] dflags,
                       input logic [19:0] pf, input logic [11:0] pflags);
        mem[dir_addr(va)] = {tf, dflags};
        mem[pte_addr(tf, va)] = {pf, pflags};
    endtask

    logic [31:0] r_pa;
    logic        r_flt;
    logic [7:0]  r_vec;
    int          r_lat, r_rd, r_wr;

    // One translation; records response, latency and memory traffic.
    task automatic xl(input logic [31:0] va, input logic w, input logic u);
        int rd0, wr0;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        rd0 = rd_cnt; wr0 = wr_cnt;
        req_valid = 1'b1; req_vaddr = va; req_write = w; req_user = u;
        @(negedge clk);
        req_valid = 1'b0;
        r_lat = 1;
        while (!rsp_valid) begin
            if (req_ready) ready_busy++;
            @(negedge clk);
            r_lat++;
        end
        r_pa = rsp_paddr; r_flt = rsp_fault; r_vec = rsp_vector;
        r_rd = rd_cnt - rd0; r_wr = wr_cnt - wr0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic inval(input logic [31:0] va);
        @(negedge clk); inv_valid = 1'b1; inv_vaddr = va;
        @(negedge clk); inv_valid = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
        chk("R1 ready", {31'h0, req_ready}, 32'h1);
        chk("R1 rsp_valid", {31'h0, rsp_valid}, 32'h0);
        chk("R1 mem_req", {31'h0, mem_req}, 32'h0);
    endtask

    task automatic t_walk_and_hit();
        logic [31:0] va = 32'h0040_3ABC;
        map(va, 20'h00200, 12'h007, 20'h12345, 12'h007);
        xl(va, 1'b0, 1'b0);
        chk("R3 walk paddr", r_pa, 32'h1234_5ABC);
        chk("R3 walk fault", {31'h0, r_flt}, 32'h0);
        chk("R3 two reads", r_rd, 2);
        chk("R4 one writeback", r_wr, 1);
        chk("R4 accessed set", mread(pte_addr(20'h00200, va)), 32'h1234_5027);
        chk("R9 ready low in walk", ready_busy, 0);
        xl(32'h0040_3010, 1'b1, 1'b1);
        chk("R2 hit paddr", r_pa, 32'h1234_5010);
        chk("R2 hit latency", r_lat, 1);
        chk("R2 hit no traffic", r_rd + r_wr, 0);
    endtask

    task automatic t_accessed_set();
        logic [31:0] va = 32'h0040_7000;
        map(va, 20'h00200, 12'h007, 20'h0ABCD, 12'h027);
        xl(va | 32'h44, 1'b0, 1'b0);
        chk("R4 no write when set", r_wr, 0);
        chk("R3 paddr", r_pa, 32'h0ABC_D044);
    endtask

    task automatic t_faults();
        logic [31:0] vd = 32'h0080_1000;
        logic [31:0] vp = 32'h00C0_2000;
        logic [31:0] vf = 32'h0100_3000;
        map(vd, 20'h00300, 12'h006, 20'h11111, 12'h007);
        map(vp, 20'h00301, 12'h007, 20'h22222, 12'h006);
        map(vf, 20'h00302, 12'h107, 20'h33333, 12'h007);
        xl(vd, 1'b0, 1'b0);
        chk("R5 dir absent fault", {31'h0, r_flt}, 32'h1);
        chk("R5 vector", {24'h0, r_vec}, 32'h5);
        chk("R5 zero paddr", r_pa, 32'h0);
        chk("R5 one read", r_rd, 1);
        xl(vd, 1'b0, 1'b0);
        chk("R5 no fill retry walks", r_rd, 1);
        xl(vp, 1'b0, 1'b0);
        chk("R5 pte absent fault", {31'h0, r_flt}, 32'h1);
        chk("R5 pte absent no write", r_wr, 0);
        xl(vf, 1'b0, 1'b0);
        chk("R5 frame bits fault", {31'h0, r_flt}, 32'h1);
    endtask

    task automatic t_perms();
        logic [31:0] vro = 32'h0140_5000;
        logic [31:0] vsu = 32'h0180_6000;
        map(vro, 20'h00400, 12'h007, 20'h44444, 12'h005);
        map(vsu, 20'h00401, 12'h007, 20'h55555, 12'h003);
        xl(vro, 1'b1, 1'b0);
        chk("R6 write ro fault", {31'h0, r_flt}, 32'h1);
        chk("R6 write ro no fill", r_wr, 0);
        xl(vro, 1'b0, 1'b1);
        chk("R6 read ro ok", r_pa, 32'h4444_4000);
        xl(vro, 1'b1, 1'b1);
        chk("R6 hit write ro fault", {31'h0, r_flt}, 32'h1);
        chk("R6 hit fault no traffic", r_rd, 0);
        xl(vsu, 1'b0, 1'b1);
        chk("R6 user on sup fault", {31'h0, r_flt}, 32'h1);
        xl(vsu, 1'b1, 1'b0);
        chk("R6 sup ok", r_pa, 32'h5555_5000);
        xl(vsu, 1'b0, 1'b1);
        chk("R6 hit user fault", {31'h0, r_flt}, 32'h1);
        chk("R6 hit user no traffic", r_rd, 0);
    endtask

    task automatic t_inval();
        inval(32'h0040_3FFF);
        xl(32'h0040_7000, 1'b0, 1'b0);
        chk("R7 other page hits", r_rd, 0);
        xl(32'h0040_3000, 1'b0, 1'b0);
        chk("R7 dropped page walks", r_rd, 2);
        chk("R7 paddr", r_pa, 32'h1234_5000);
    endtask

    task automatic t_inval_fill();
        logic [31:0] va = 32'h01C0_8000;
        map(va, 20'h00500, 12'h007, 20'h66666, 12'h027);
        @(negedge clk); inv_valid = 1'b1; inv_vaddr = va;
        xl(va, 1'b0, 1'b0);
        @(negedge clk); inv_valid = 1'b0;
        chk("R10 paddr still right", r_pa, 32'h6666_6000);
        xl(va, 1'b0, 1'b0);
        chk("R10 fill dropped", r_rd, 2);
    endtask

    task automatic t_round_robin();
        logic [31:0] va;
        for (int i = 0; i < 10; i++) begin
            va = 32'h0400_0000 + (i << 12);
            map(va, 20'h00600, 12'h007, 20'h70000 + i, 12'h027);
        end
        xl(32'h0040_7000, 1'b0, 1'b0);
        do_reset();
        xl(32'h0040_7000, 1'b0, 1'b0);
        chk("R1 cache empty after reset", r_rd, 2);
        do_reset();
        for (int i = 0; i < 9; i++) xl(32'h0400_0000 + (i << 12), 1'b0, 1'b0);
        xl(32'h0400_0000, 1'b0, 1'b0);
        chk("R8 first page evicted", r_rd, 2);
        xl(32'h0400_2000, 1'b0, 1'b0);
        chk("R8 third page kept", r_rd, 0);
        chk("R8 paddr", r_pa, 32'h7000_2000);
        xl(32'h0400_1000, 1'b0, 1'b0);
        chk("R8 second page evicted", r_rd, 2);
    endtask

    initial begin
        t_reset();
        t_walk_and_hit();
        t_accessed_set();
        t_faults();
        t_perms();
        t_inval();
        t_inval_fill();
        t_round_robin();
        chk("R9 ready never high mid-walk", ready_busy, 0);
        fin();
    end
endmodule